// File: doc/BRIEF.md
# Binary-Coded Ternary Storage Register

This block stores a word of balanced-ternary digits (trits). Each trit is kept as a pair of ordinary binary flip-flops, so a word of six trits occupies twelve bits. A ternary control input chooses between following the data input and remembering the current contents. All inputs are sampled only on the rising edge of a binary clock. Because of this, a control signal that passes through an intermediate value on its way between states cannot disturb the stored word.

A synchronous, active-low reset forces every stored trit to minus one. The data input is also screened. A trit that arrives with the unused bit pair is reported on an error output in the same cycle. If that word is loaded, the faulty trit is stored as zero, so the register never holds an illegal code.

Top module: `bct_trit_register`

## Requirements
- R1: Trit codes are: minus one = 2'b10, zero = 2'b00, plus one = 2'b01, and 2'b11 is illegal. Trit k of a word sits in bits [2k+1:2k]. The default word holds 6 trits, which is 12 bits.
- R2: When `rst_n` is low at a rising clock edge, `data_out` reads 12'b101010101010 after that edge, whatever `enable_code` and `data_in` are.
- R3: When `rst_n` is high and `enable_code` is 2'b01 (plus one) at a rising edge, `data_out` takes the value of `data_in` after that edge, apart from the substitution in R8.
- R4: When `enable_code` is 2'b10 (minus one) at a rising edge, `data_out` keeps its value.
- R5: When `enable_code` is 2'b00 (zero) at a rising edge, `data_out` keeps its value. A brief pass through zero between minus one and plus one therefore loads nothing.
- R6: When `enable_code` is the illegal pair 2'b11 at a rising edge, `data_out` keeps its value.
- R7: `code_err` is high in any cycle in which at least one trit of `data_in` is 2'b11, and low otherwise. This holds for every value of the enable.
- R8: When a word is loaded, each input trit that is 2'b11 is stored as 2'b00. The legal trits of the same word are stored unchanged.
- R9: No trit of `data_out` is ever 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Binary clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; sets every trit to minus one |
| enable_code | input | 2 | Ternary enable: plus one loads, any other code holds |
| data_in | input | 12 | Input word, six two-bit trit codes |
| code_err | output | 1 | High while any input trit carries the illegal pair |
| data_out | output | 12 | Stored word, six two-bit trit codes |

## Verification
The assertions assume that `enable_code` and `data_in` are stable around the rising edge. Only their sampled values matter, so any glitch between edges is invisible to the design and to the checks. The assertions also assume that reset is applied before any checked cycle. The stimulus changes inputs only at the falling edge and holds reset low for the first cycles. Random words include the illegal pair on purpose. The random enable draws from all four codes, and directed runs of minus one, zero, plus one imitate a glitching enable.

// File: rtl/bct_pkg.sv
// Package: shared trit encoding and helpers for the binary-coded ternary register.
// Assumes two bits per trit; the pair 2'b11 carries no value.
package bct_pkg;

    localparam int TRIT_BITS = 2;

    typedef enum logic [1:0] {
        TRIT_ZERO = 2'b00,
        TRIT_POS  = 2'b01,
        TRIT_NEG  = 2'b10,
        TRIT_BAD  = 2'b11
    } trit_code_e;

    // Replace the illegal code by zero; legal codes pass unchanged.
    function automatic logic [1:0] trit_clean(input logic [1:0] code);
        return (code == TRIT_BAD) ? TRIT_ZERO : code;
    endfunction

    // Report whether a two-bit pair is the illegal code.
    function automatic logic trit_is_bad(input logic [1:0] code);
        return (code == TRIT_BAD);
    endfunction

endpackage

// File: rtl/bct_enable_decode.sv
// Module: bct_enable_decode
// Turns the ternary enable into a single load strobe. Only plus one loads.
// Minus one, zero and the illegal pair all mean hold, so a pass through
// zero never starts a load. Assumes the enable is sampled at the clock edge
// by the storage cells that use the strobe.
module bct_enable_decode
    import bct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] enable_code,
    output logic       load_en
);

    // Decode: assert the load strobe for the plus-one code only.
    always_comb begin
        unique case (enable_code)
            TRIT_POS: load_en = 1'b1;
            TRIT_NEG,
            TRIT_ZERO,
            TRIT_BAD: load_en = 1'b0;
            default:  load_en = 1'b0;
        endcase
    end

    // R5/R6: the zero and illegal codes must never request a load.
    a_r5_zero_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_code != TRIT_POS) |-> !load_en);

endmodule

// File: rtl/bct_code_screen.sv
// Module: bct_code_screen
// Checks each trit of the input word for the illegal pair. It produces a
// cleaned word, with zero put in place of every bad trit, and a per-trit
// fault vector. Purely combinational; assumes trit k sits in bits [2k+1:2k].
module bct_code_screen
    import bct_pkg::*;
#(
    parameter int NUM_TRITS = 6,
    localparam int WORD_W   = NUM_TRITS * TRIT_BITS
) (
    input  logic [WORD_W-1:0]    word_in,
    output logic [WORD_W-1:0]    word_clean,
    output logic [NUM_TRITS-1:0] trit_fault,
    output logic                 any_fault
);

    for (genvar k = 0; k < NUM_TRITS; k++) begin : g_trit
        logic [1:0] raw;
        assign raw = word_in[k*TRIT_BITS +: TRIT_BITS];

        // Screen one trit: flag the illegal pair and substitute zero.
        always_comb begin
            trit_fault[k]                        = trit_is_bad(raw);
            word_clean[k*TRIT_BITS +: TRIT_BITS] = trit_clean(raw);
        end

        // R8: a cleaned trit is zero exactly where the raw trit was faulty or zero.
        a_r8_clean_trit: assert final (trit_fault[k] == (raw == 2'b11)
            && (trit_fault[k] ? (word_clean[k*TRIT_BITS +: TRIT_BITS] == 2'b00)
                              : (word_clean[k*TRIT_BITS +: TRIT_BITS] == raw)));
    end

    // Combine the per-trit faults into one flag for the word.
    always_comb begin
        any_fault = |trit_fault;
    end

endmodule

// File: rtl/bct_trit_cell.sv
// Module: bct_trit_cell
// Holds one trit as two ordinary flip-flops. A synchronous active-low reset
// writes minus one and takes priority over the load strobe. Assumes its data
// input is already cleaned, so it never carries the illegal pair.
module bct_trit_cell
    import bct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_en,
    input  logic [1:0] trit_in,
    output logic [1:0] trit_q
);

    logic past_valid;
    logic rst_seen_low;

    // Storage: reset to minus one, otherwise load or keep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trit_q <= TRIT_NEG;
        end else if (load_en) begin
            trit_q <= trit_in;
        end
    end

    // Checker history: one clock seen, and whether reset was low on it.
    always_ff @(posedge clk) begin
        past_valid   <= 1'b1;
        rst_seen_low <= !rst_n;
    end

    // R2: after a reset edge the cell holds minus one.
    always_ff @(posedge clk) begin
        if (past_valid === 1'b1 && rst_seen_low === 1'b1) begin
            a_r2_reset_neg: assert (trit_q == 2'b10);
        end
    end

    // R4: without a load strobe the cell keeps its value.
    a_r4_hold_cell: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(trit_q));

    // R3: with a load strobe the cell takes the presented trit.
    a_r3_load_cell: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (trit_q == $past(trit_in)));

    // R9: the cell never holds the illegal pair once reset has run.
    a_r9_no_bad_state: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid |-> (trit_q != 2'b11));

endmodule

// File: rtl/bct_trit_register.sv
// Module: bct_trit_register
// A word of balanced-ternary digits, each held as a binary pair. The ternary
// enable loads on plus one and holds on any other code. Inputs are sampled
// only at the rising clock edge, so glitches on the enable have no effect.
// Illegal input trits are flagged in the same cycle and stored as zero.
module bct_trit_register
    import bct_pkg::*;
#(
    parameter int NUM_TRITS = 6,
    localparam int WORD_W   = NUM_TRITS * TRIT_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        enable_code,
    input  logic [WORD_W-1:0] data_in,
    output logic              code_err,
    output logic [WORD_W-1:0] data_out
);

    localparam logic [WORD_W-1:0] RESET_WORD = {NUM_TRITS{TRIT_NEG}};

    logic                 load_en;
    logic [WORD_W-1:0]    clean_word;
    logic [NUM_TRITS-1:0] fault_vec;
    logic                 past_valid;

    bct_enable_decode u_enable (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_code (enable_code),
        .load_en     (load_en)
    );

    bct_code_screen #(.NUM_TRITS(NUM_TRITS)) u_screen (
        .word_in    (data_in),
        .word_clean (clean_word),
        .trit_fault (fault_vec),
        .any_fault  (code_err)
    );

    for (genvar k = 0; k < NUM_TRITS; k++) begin : g_cell
        bct_trit_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_en (load_en),
            .trit_in (clean_word[k*TRIT_BITS +: TRIT_BITS]),
            .trit_q  (data_out[k*TRIT_BITS +: TRIT_BITS])
        );
    end

    // Checker history: at least one clock edge has passed.
    always_ff @(posedge clk) begin
        past_valid <= 1'b1;
    end

    // R3: a legal word presented with plus one appears unchanged on the output.
    a_r3_word_load: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_code == 2'b01 && !code_err) |=> (data_out == $past(data_in)));

    // R5: an enable of zero leaves the word untouched.
    a_r5_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_code == 2'b00) |=> $stable(data_out));

    // R4: an enable of minus one leaves the word untouched.
    a_r4_neg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_code == 2'b10) |=> $stable(data_out));

    // R6: the illegal enable code leaves the word untouched.
    a_r6_bad_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_code == 2'b11) |=> $stable(data_out));

    // R2: a reset edge yields the all-minus-one word.
    a_r2_reset_word: assert property (@(posedge clk)
        (past_valid && !rst_n) |=> (data_out == RESET_WORD));

    // R7: the error flag is high on a word that holds no legal trit anywhere.
    a_r7_all_bad_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (data_in == {WORD_W{1'b1}}) |-> code_err);

endmodule

// File: tb/bct_trit_register_bench.sv
module bct_trit_register_bench;

    localparam int  CLK_PERIOD = 10;
    localparam int  TRITS      = 6;
    localparam int  W          = 2 * TRITS;
    localparam int  WATCHDOG   = 20000;
    localparam logic [W-1:0] RST_WORD = 12'b101010101010;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   enable_code = 2'b00;
    logic [W-1:0] data_in = '0;
    logic         code_err;
    logic [W-1:0] data_out;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] model;
    bit   done = 1'b0;

    bct_trit_register u_bct_trit_register (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_code (enable_code),
        .data_in     (data_in),
        .code_err    (code_err),
        .data_out    (data_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected cleaned word: bad trits become zero (R8).
    function automatic logic [W-1:0] exp_clean(input logic [W-1:0] w);
        logic [W-1:0] r = w;
        for (int k = 0; k < TRITS; k++)
            if (w[2*k +: 2] == 2'b11) r[2*k +: 2] = 2'b00;
        return r;
    endfunction

    // Expected error flag (R7).
    function automatic logic exp_err(input logic [W-1:0] w);
        logic e = 1'b0;
        for (int k = 0; k < TRITS; k++)
            if (w[2*k +: 2] == 2'b11) e = 1'b1;
        return e;
    endfunction

    function automatic logic has_bad(input logic [W-1:0] w);
        return exp_err(w);
    endfunction

    task automatic check_word(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Apply one cycle at the falling edge, check the flag, then the stored word.
    task automatic cycle(input string req, input logic rn, input logic [1:0] en, input logic [W-1:0] d);
        @(negedge clk);
        rst_n = rn; enable_code = en; data_in = d;
        #1;
        check_bit({req, " R7 flag"}, code_err, exp_err(d));
        if (!rn)             model = RST_WORD;
        else if (en == 2'b01) model = exp_clean(d);
        @(posedge clk);
        @(negedge clk);
        check_word(req, data_out, model);
        check_bit("R9 legal output", has_bad(data_out), 1'b0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin : main
        logic [1:0] en_r;
        logic [W-1:0] d_r;
        void'($urandom(32'h0BC7_2026));
        model = RST_WORD;
        // R2: reset with a load request still yields the reset word
        cycle("R2 reset", 1'b0, 2'b01, 12'b010101010101);
        cycle("R2 reset hold", 1'b0, 2'b00, 12'b000000000000);
        // R1/R3: load each legal code in known positions
        cycle("R3 load R1 codes", 1'b1, 2'b01, 12'b100001100001);
        cycle("R4 hold minus one", 1'b1, 2'b10, 12'b010101010101);
        cycle("R5 hold zero", 1'b1, 2'b00, 12'b000000000000);
        cycle("R6 hold illegal enable", 1'b1, 2'b11, 12'b011001100110);
        // R5: glitching enable minus one, zero, plus one
        cycle("R5 glitch neg", 1'b1, 2'b10, 12'b000101000100);
        cycle("R5 glitch zero", 1'b1, 2'b00, 12'b000101000100);
        cycle("R3 glitch pos", 1'b1, 2'b01, 12'b000101000100);
        // R8: illegal trits in the word being loaded
        cycle("R8 one bad trit", 1'b1, 2'b01, 12'b101101100001);
        cycle("R8 all bad", 1'b1, 2'b01, 12'b111111111111);
        // R7: flag raised while holding, store unchanged
        cycle("R7 flag on hold", 1'b1, 2'b10, 12'b110000000000);
        cycle("R2 reset mid-run", 1'b0, 2'b01, 12'b000000000000);
        // Random stimulus over all enable codes and words
        for (int i = 0; i < 400; i++) begin
            en_r = 2'($urandom);
            d_r  = W'($urandom);
            cycle("R3/R4/R5/R6/R8 random", ($urandom % 16) != 0, en_r, d_r);
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule